// File: doc/BRIEF.md
# Dual-Rail / One-Hot-Quaternary Signal Converter Pair

This block translates between two encodings used on return-to-zero datapaths. The merge unit takes two dual-rail bits and produces one four-wire one-hot symbol. The split unit takes one four-wire symbol and produces two dual-rail bits. Every data word on any of these wires is followed by an all-low spacer before the next word may appear.

The merge unit keeps a completion state between the spacer and data phases. It stays at spacer until both inputs carry valid data. It then holds the symbol it produced until both inputs have gone back to spacer. A merge therefore never emits a symbol built from half of a word. The split unit decodes each one-hot symbol in a single cycle.

Illegal codes set a sticky error flag that stays set until reset, and force the affected output to spacer. Both units are replicated per lane by a parameter. Both units register their outputs and use a synchronous active-high reset.

The valid/ready convention does not apply to this block. The spacer/data alternation itself is the handshake, and there is no back-pressure path.

Top module: `dq_conv_top`

## Requirements
- R1: While reset is asserted, and on the cycle after it, every data output is all-low and both error flags are low.
- R2: Dual-rail code 01 means 0 and code 10 means 1. The merge output is the one-hot value {hi,lo}, where hi is the first input: 0→0001, 1→0010, 2→0100, 3→1000. The output appears on the clock edge after the edge that captures both inputs valid.
- R3: While either merge input is still spacer (00), the merge output stays 0000. This holds for staggered arrival in either order.
- R4: Once a symbol has been emitted, it stays on the output while at least one input is non-spacer. The output returns to 0000 on the edge after both inputs are 00.
- R5: A change of input data during the data phase, before both inputs have returned to spacer, has no effect on the merge output.
- R6: A split input of 0000 gives 00 on both dual-rail outputs on the next edge.
- R7: A split input with exactly one wire high gives both dual-rail outputs on the same next edge, using the same mapping as R2.
- R8: A merge input of 11 on either rail pair sets the merge error flag on the next edge. The merge output is 0000 from that edge onward, and the flag stays set until reset, whatever the later inputs are.
- R9: A split input with more than one wire high sets the split error flag on the next edge. Both split outputs are 00 from then on, and the flag stays set until reset.
- R10: Feeding the merge output into the split input reproduces the original pair of bits for all four values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| mrg_hi | input | 2*LANES | merge input, high bit, dual-rail per lane |
| mrg_lo | input | 2*LANES | merge input, low bit, dual-rail per lane |
| mrg_sym | output | 4*LANES | merge output, one-hot symbol per lane |
| mrg_err | output | 1 | sticky merge protocol error |
| spl_sym | input | 4*LANES | split input, one-hot symbol per lane |
| spl_hi | output | 2*LANES | split output, high bit, dual-rail |
| spl_lo | output | 2*LANES | split output, low bit, dual-rail |
| spl_err | output | 1 | sticky split protocol error |

## Verification
A merge unit whose completion state was lost would show up on `mrg_sym` one edge after the first input arrives. It would either emit a symbol while the other input is still spacer, or drop the symbol to 0000 while one input is still high, so staggered sequences expose it within a single cycle. A wrong decode in either unit shows up as a mismatched value in the round trip two edges after the word completes. A lost sticky error shows up as an error flag that drops, or as data leaking out on the first legal word after the fault.

// File: rtl/dq_conv_pkg.sv
package dq_conv_pkg;
  localparam int RAIL_W = 2;
  localparam int SYM_W  = 4;
  localparam logic [RAIL_W-1:0] RAIL_NULL = 2'b00;
  localparam logic [RAIL_W-1:0] RAIL_ZERO = 2'b01;
  localparam logic [RAIL_W-1:0] RAIL_ONE  = 2'b10;
  localparam logic [RAIL_W-1:0] RAIL_BAD  = 2'b11;

  function automatic logic rail_ok(input logic [RAIL_W-1:0] r);
    return (r == RAIL_ZERO) || (r == RAIL_ONE);
  endfunction

  function automatic logic [SYM_W-1:0] sym_of(input logic hi, input logic lo);
    logic [SYM_W-1:0] s;
    s = '0;
    s[{hi, lo}] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/dq_merge_lane.sv
module dq_merge_lane
  import dq_conv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [RAIL_W-1:0] hi_in,
  input  logic [RAIL_W-1:0] lo_in,
  output logic [SYM_W-1:0]  sym_out,
  output logic              err_out
);
  logic both_ok, both_null, bad_code;

  always_comb begin
    both_ok   = rail_ok(hi_in) && rail_ok(lo_in);
    both_null = (hi_in == RAIL_NULL) && (lo_in == RAIL_NULL);
    bad_code  = (hi_in == RAIL_BAD) || (lo_in == RAIL_BAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_out <= '0;
      err_out <= 1'b0;
    end else if (err_out || bad_code) begin
      err_out <= 1'b1;
      sym_out <= '0;
    end else if (sym_out == '0) begin
      if (both_ok) sym_out <= sym_of(hi_in == RAIL_ONE, lo_in == RAIL_ONE);
    end else if (both_null) begin
      sym_out <= '0;
    end
  end

  // R2
  sym_onehot0_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sym_out));
  // R3
  no_partial_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_out == '0 && !both_ok) |=> sym_out == '0);
  // R4
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_out != '0 && !both_null) |=> (sym_out == $past(sym_out)) || err_out);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_out |=> err_out);
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_out |-> sym_out == '0);
endmodule

// File: rtl/dq_split_lane.sv
module dq_split_lane
  import dq_conv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SYM_W-1:0]  sym_in,
  output logic [RAIL_W-1:0] hi_out,
  output logic [RAIL_W-1:0] lo_out,
  output logic              err_out
);
  logic multi_hot;

  always_comb multi_hot = ($countones(sym_in) > 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_out  <= RAIL_NULL;
      lo_out  <= RAIL_NULL;
      err_out <= 1'b0;
    end else if (err_out || multi_hot) begin
      err_out <= 1'b1;
      hi_out  <= RAIL_NULL;
      lo_out  <= RAIL_NULL;
    end else if (sym_in == '0) begin
      hi_out <= RAIL_NULL;
      lo_out <= RAIL_NULL;
    end else begin
      hi_out <= (sym_in[3] | sym_in[2]) ? RAIL_ONE : RAIL_ZERO;
      lo_out <= (sym_in[3] | sym_in[1]) ? RAIL_ONE : RAIL_ZERO;
    end
  end

  // R6
  spacer_out_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_in == '0) |=> (hi_out == RAIL_NULL && lo_out == RAIL_NULL));
  // R7
  both_decoded_chk: assert property (@(posedge clk) disable iff (rst)
    ($onehot(sym_in) && !err_out) |=> (rail_ok(hi_out) && rail_ok(lo_out)));
  // R9
  split_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_out |=> err_out);
  // R9
  split_err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_out |-> (hi_out == RAIL_NULL && lo_out == RAIL_NULL));
endmodule

// File: rtl/dq_conv_top.sv
module dq_conv_top
  import dq_conv_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [RAIL_W*LANES-1:0] mrg_hi,
  input  logic [RAIL_W*LANES-1:0] mrg_lo,
  output logic [SYM_W*LANES-1:0]  mrg_sym,
  output logic                    mrg_err,
  input  logic [SYM_W*LANES-1:0]  spl_sym,
  output logic [RAIL_W*LANES-1:0] spl_hi,
  output logic [RAIL_W*LANES-1:0] spl_lo,
  output logic                    spl_err
);
  logic [LANES-1:0] m_err, s_err;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dq_merge_lane u_mrg (
      .clk     (clk),
      .rst     (rst),
      .hi_in   (mrg_hi[g*RAIL_W +: RAIL_W]),
      .lo_in   (mrg_lo[g*RAIL_W +: RAIL_W]),
      .sym_out (mrg_sym[g*SYM_W +: SYM_W]),
      .err_out (m_err[g])
    );
    dq_split_lane u_spl (
      .clk     (clk),
      .rst     (rst),
      .sym_in  (spl_sym[g*SYM_W +: SYM_W]),
      .hi_out  (spl_hi[g*RAIL_W +: RAIL_W]),
      .lo_out  (spl_lo[g*RAIL_W +: RAIL_W]),
      .err_out (s_err[g])
    );
  end

  assign mrg_err = |m_err;
  assign spl_err = |s_err;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (mrg_sym == '0 && spl_hi == '0 && spl_lo == '0 && !mrg_err && !spl_err));
endmodule

// File: tb/dq_conv_top_tb_top.sv
module dq_conv_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] a_in = 2'b00, b_in = 2'b00;
  logic [3:0] sym_man = 4'b0000;
  logic       chain = 1'b0;
  logic [3:0] m_sym, s_in;
  logic [1:0] s_hi, s_lo;
  logic       m_err, s_err;
  int         checks = 0, bad = 0;
  logic [1:0] expq[$];
  logic       prev_null = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign s_in = chain ? m_sym : sym_man;

  dq_conv_top dut_i (
    .clk(clk), .rst(rst), .mrg_hi(a_in), .mrg_lo(b_in), .mrg_sym(m_sym),
    .mrg_err(m_err), .spl_sym(s_in), .spl_hi(s_hi), .spl_lo(s_lo), .spl_err(s_err)
  );

  function automatic logic [1:0] rail(input logic v);
    return v ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; a_in = 2'b00; b_in = 2'b00; sym_man = 4'b0000;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  // mode 0: together, 1: hi first, 2: lo first
  task automatic send(input logic [1:0] v, input int mode);
    logic [3:0] e;
    e = 4'b0001 << v;
    @(negedge clk);
    if (mode == 0) begin a_in = rail(v[1]); b_in = rail(v[0]); end
    else if (mode == 1) a_in = rail(v[1]);
    else b_in = rail(v[0]);
    if (mode != 0) begin
      @(negedge clk) chk(m_sym == 4'b0000, "R3 partial", {4'b0, m_sym}, 8'h00);
      @(negedge clk) chk(m_sym == 4'b0000, "R3 partial", {4'b0, m_sym}, 8'h00);
      if (mode == 1) b_in = rail(v[0]); else a_in = rail(v[1]);
    end
    expq.push_back(v);
    @(negedge clk) chk(m_sym == e, "R2 encode", {4'b0, m_sym}, {4'b0, e});
    if (mode == 1) a_in = 2'b00; else b_in = 2'b00;
    @(negedge clk) chk(m_sym == e, "R4 hold", {4'b0, m_sym}, {4'b0, e});
    a_in = 2'b00; b_in = 2'b00;
    @(negedge clk) chk(m_sym == 4'b0000, "R4 release", {4'b0, m_sym}, 8'h00);
    @(negedge clk);
  endtask

  // scoreboard monitor for the round trip (R10)
  always @(negedge clk) begin
    if (!rst && chain) begin
      logic cur_null;
      cur_null = (s_hi == 2'b00) && (s_lo == 2'b00);
      if (prev_null && !cur_null) begin
        if (expq.size() == 0) chk(1'b0, "R10 unexpected", {4'b0, s_hi, s_lo}, 8'h00);
        else begin
          logic [1:0] ev;
          ev = expq.pop_front();
          chk(s_hi == rail(ev[1]) && s_lo == rail(ev[0]), "R10 R7 roundtrip",
              {4'b0, s_hi, s_lo}, {4'b0, rail(ev[1]), rail(ev[0])});
        end
      end
      prev_null = cur_null;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 8'h00, 8'h01);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(m_sym == 0 && s_hi == 0 && s_lo == 0 && !m_err && !s_err, "R1 reset",
        {m_err, s_err, m_sym, 2'b0}, 8'h00);
    rst = 1'b0;

    chain = 1'b1;
    for (int v = 0; v < 4; v++) send(v[1:0], 0);
    for (int v = 0; v < 4; v++) send(v[1:0], 1);
    for (int v = 0; v < 4; v++) send(v[1:0], 2);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R10 drained", 8'(expq.size()), 8'h00);

    // R5: data change during data phase is ignored
    @(negedge clk) begin a_in = 2'b01; b_in = 2'b10; end
    @(negedge clk) chk(m_sym == 4'b0010, "R5 setup", {4'b0, m_sym}, 8'h02);
    expq.push_back(2'b01);
    a_in = 2'b10; b_in = 2'b01;
    @(negedge clk) chk(m_sym == 4'b0010, "R5 ignore", {4'b0, m_sym}, 8'h02);
    @(negedge clk) chk(m_sym == 4'b0010, "R5 ignore", {4'b0, m_sym}, 8'h02);
    a_in = 2'b00; b_in = 2'b00;
    repeat (3) @(negedge clk);
    chain = 1'b0;

    // R6, R7 direct split checks
    sym_man = 4'b0100;
    @(negedge clk) chk(s_hi == 2'b10 && s_lo == 2'b01, "R7 decode 2", {4'b0, s_hi, s_lo}, 8'h09);
    sym_man = 4'b1000;
    @(negedge clk) chk(s_hi == 2'b10 && s_lo == 2'b10, "R7 decode 3", {4'b0, s_hi, s_lo}, 8'h0a);
    sym_man = 4'b0000;
    @(negedge clk) chk(s_hi == 2'b00 && s_lo == 2'b00, "R6 spacer", {4'b0, s_hi, s_lo}, 8'h00);

    // R9 split error
    sym_man = 4'b0110;
    @(negedge clk) chk(s_err && s_hi == 0 && s_lo == 0, "R9 split err", {3'b0, s_err, s_hi, s_lo}, 8'h10);
    sym_man = 4'b0001;
    @(negedge clk) chk(s_err && s_hi == 0 && s_lo == 0, "R9 sticky", {3'b0, s_err, s_hi, s_lo}, 8'h10);
    sym_man = 4'b0000;

    // R8 merge error
    do_reset();
    chk(!m_err && !s_err, "R1 after reset", {6'b0, m_err, s_err}, 8'h00);
    a_in = 2'b11; b_in = 2'b01;
    @(negedge clk) chk(m_err && m_sym == 0, "R8 merge err", {3'b0, m_err, m_sym}, 8'h10);
    a_in = 2'b10; b_in = 2'b10;
    @(negedge clk) chk(m_err && m_sym == 0, "R8 sticky", {3'b0, m_err, m_sym}, 8'h10);
    @(negedge clk) chk(m_err && m_sym == 0, "R8 sticky", {3'b0, m_err, m_sym}, 8'h10);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule